// File: doc/BRIEF.md
# Fixed-Head Disk Controller Register Interface

This block is the bus-facing register file of a head-per-track disk DMA controller. A host reads and writes eight 16-bit word registers, in word or byte form. The control/status word is assembled on every read from stored control fields and from error flags that the transfer engine reports. Two summary bits are also folded in: a freeze bit computed from the address-extension error field, and a non-existent-disk bit computed by comparing the full disk address with the attached capacity.

When software launches an operation, the block raises a one-cycle start strobe and presents the two-bit function code. The transfer engine sits outside this block. It reads the memory address, disk address, word count and address-inhibit outputs, and it writes back progress through a load strobe. It reports completion and errors through single-cycle flag inputs. The block drives one level-sensitive interrupt request, which is dropped by an acknowledge input. The bus side uses plain strobes with no back-pressure: every strobed access completes in the cycle it is presented, and read data is combinational from the address.

Top module: `dkc_regfile`

## Requirements
- R1: Register select is `bus_addr[3:1]`: 0 control/status, 1 word count, 2 memory address, 3 disk address, 4 address extension, 5 data buffer, 6 maintenance, 7 rotational position. Index 7 reads `rot_pos`, and writes to it are ignored. A word write to index 1, 3, 5 or 6 stores all 16 bits, and the stored value reads back the same.
- R2: A byte write (`bus_byte`=1) with `bus_addr[0]`=1 replaces only bits 15:8, taken from `bus_wdata[15:8]`. With `bus_addr[0]`=0 it replaces only bits 7:0, taken from `bus_wdata[7:0]`.
- R3: A control/status write keeps only interrupt enable (bit 6), memory extension (bits 5:4) and function (bits 2:1). Bits 15:9 read the flags, bit 7 reads DONE, and bits 8, 3 and 0 read 0. Writing bit 8 as 1 returns the whole block to its reset state, drops the rest of that write, and pulses `abort_pulse` for one cycle.
- R4: Writing bit 0 (GO) starts an operation only when DONE is set and the newly written function is nonzero. A start raises `start_pulse` in the next cycle with `func_code` equal to that function. It clears DONE and the flags at bits 13, 12, 10 and 9.
- R5: Bit 15 (error) reads 1 exactly when any of bits 14 to 9 is 1. `eng_cs_err[3:0]` sets bits 13, 12, 10 and 9 respectively.
- R6: Each bit of `eng_dae_err[5:0]` sets bit 10+j of the address extension register. Bit 10 is the non-existent-memory flag. These bits are cleared only by reset or a clear. Control/status bit 14 (freeze) reads 1 exactly when any of them is set.
- R7: Control/status bit 11 reads 1 exactly when {extension bits 5:0, disk address} is at or above `cap_words`.
- R8: `irq` rises when enable is 1 and DONE goes from 0 to 1. It also rises when enable is written from 0 to 1 while DONE is 1. It falls on a control/status write with bit 6 = 0, on `irq_ack`, or on a clear.
- R9: Memory address bit 0 always stores and reads 0. The address extension register accepts writes only to bits 8, 7 and 5:0 (mask octal 0677), and reads bits 15:10, 8, 7 and 5:0.
- R10: After reset, control/status reads 0x0080 (DONE only). All other stored registers read 0, and `irq`, `start_pulse` and `abort_pulse` are low.
- R11: `eng_upd` loads the word count, the 18-bit memory address (bits 17:16 into the extension field) and the 22-bit disk address (bits 21:16 into extension bits 5:0). `eng_dbr_we` loads the data buffer, and `eng_done` sets DONE. `mem_addr`, `disk_addr`, `word_cnt` and `addr_inh` (extension bit 8) reflect the stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write access |
| bus_byte | input | 1 | 1 = byte write |
| bus_addr | input | 4 | Register address; [3:1] select, [0] byte lane |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| eng_upd | input | 1 | Engine loads progress registers |
| eng_wc | input | 16 | Word count to load |
| eng_ma | input | 18 | Memory address to load |
| eng_da | input | 22 | Disk address to load |
| eng_dbr_we | input | 1 | Load data buffer |
| eng_dbr | input | 16 | Data buffer value |
| eng_done | input | 1 | Operation complete |
| eng_cs_err | input | 4 | Status error set strobes |
| eng_dae_err | input | 6 | Extension error set strobes |
| irq_ack | input | 1 | Interrupt acknowledge |
| rot_pos | input | 16 | Rotational position |
| cap_words | input | 23 | Attached capacity in words |
| mem_addr | output | 18 | Current memory address |
| disk_addr | output | 22 | Current disk address |
| word_cnt | output | 16 | Current word count |
| addr_inh | output | 1 | Memory address increment inhibit |
| func_code | output | 2 | Function code |
| start_pulse | output | 1 | Operation start strobe |
| abort_pulse | output | 1 | Controller clear strobe |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted control field or flag shows up on the next read of the control/status word, because that word is rebuilt combinationally from stored state. A bad summary computation therefore shows in the same cycle as the fault. A wrong DONE or enable value shows one edge later, as a missing or spurious `irq` or `start_pulse`. A lost bit in the memory address or extension masks, or a wrong byte lane, shows on the first readback after the write that exposes it.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int REG_W  = 16;
  localparam int HALF_W = REG_W / 2;
  localparam int NREG   = 8;
  localparam int SEL_W  = $clog2(NREG);
  localparam int MEX_W  = 2;
  localparam int EXT_W  = 6;
  localparam int NFLAG  = 4;
  localparam int NDERR  = 6;
  localparam int MA_W   = REG_W + MEX_W;
  localparam int DA_W   = REG_W + EXT_W;

  typedef enum logic [SEL_W-1:0] {
    RI_CS, RI_WC, RI_MA, RI_DA, RI_DAE, RI_DBR, RI_MNT, RI_POS
  } reg_idx_t;

  localparam int CS_ERR  = 15;
  localparam int CS_FRZ  = 14;
  localparam int CS_NED  = 11;
  localparam int CS_CLR  = 8;
  localparam int CS_DONE = 7;
  localparam int CS_IE   = 6;
  localparam int CS_MEXL = 4;
  localparam int CS_FNL  = 1;
  localparam int CS_GO   = 0;
  localparam int DAE_ERRL = 10;
  localparam int DAE_INH  = 8;

  localparam logic [REG_W-1:0] DAE_WMASK = 16'o000677;
  localparam logic [REG_W-1:0] DAE_RMASK = 16'o176677;
endpackage

// File: rtl/dkc_bus_merge.sv
module dkc_bus_merge
  import dkc_pkg::*;
(
  input  logic             sel,
  input  logic             wr,
  input  logic             byte_wr,
  input  logic [3:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] cur,
  output logic [NREG-1:0]  we,
  output logic [REG_W-1:0] mval
);
  logic [SEL_W-1:0] idx;
  assign idx = addr[SEL_W:1];

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    if (i == int'(RI_POS)) begin : g_ro
      assign we[i] = 1'b0;
    end else begin : g_rw
      assign we[i] = sel && wr && (idx == SEL_W'(i));
    end
  end

  always_comb begin
    if (!byte_wr)
      mval = wdata;
    else if (addr[0])
      mval = {wdata[REG_W-1:HALF_W], cur[HALF_W-1:0]};
    else
      mval = {cur[REG_W-1:HALF_W], wdata[HALF_W-1:0]};
  end
endmodule

// File: rtl/dkc_status.sv
module dkc_status
  import dkc_pkg::*;
#(
  parameter int CAP_W = 23
) (
  input  logic [NFLAG-1:0] flags,
  input  logic [NDERR-1:0] dae_err,
  input  logic [DA_W-1:0]  full_da,
  input  logic [CAP_W-1:0] cap,
  output logic             frz,
  output logic             ned,
  output logic             err
);
  localparam int CMP_W = (CAP_W > DA_W) ? CAP_W : DA_W;

  logic [CMP_W-1:0] da_x, cap_x;
  assign da_x  = CMP_W'(full_da);
  assign cap_x = CMP_W'(cap);

  assign frz = |dae_err;
  assign ned = (da_x >= cap_x);
  assign err = frz | ned | (|flags);
endmodule

// File: rtl/dkc_irq.sv
module dkc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ie_q,
  input  logic ie_wr,
  input  logic ie_new,
  input  logic done_q,
  input  logic done_set,
  input  logic ack,
  output logic irq
);
  logic rise_done, rise_ie;
  assign rise_done = ie_q && done_set && !done_q;
  assign rise_ie   = ie_wr && ie_new && !ie_q && done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  irq <= 1'b0;
    else if (clr)                irq <= 1'b0;
    else if (ie_wr && !ie_new)   irq <= 1'b0;
    else if (rise_done || rise_ie) irq <= 1'b1;
    else if (ack)                irq <= 1'b0;
  end
endmodule

// File: rtl/dkc_regfile.sv
module dkc_regfile
  import dkc_pkg::*;
#(
  parameter int CAP_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_byte,
  input  logic [3:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             eng_upd,
  input  logic [REG_W-1:0] eng_wc,
  input  logic [MA_W-1:0]  eng_ma,
  input  logic [DA_W-1:0]  eng_da,
  input  logic             eng_dbr_we,
  input  logic [REG_W-1:0] eng_dbr,
  input  logic             eng_done,
  input  logic [NFLAG-1:0] eng_cs_err,
  input  logic [NDERR-1:0] eng_dae_err,
  input  logic             irq_ack,
  input  logic [REG_W-1:0] rot_pos,
  input  logic [CAP_W-1:0] cap_words,
  output logic [MA_W-1:0]  mem_addr,
  output logic [DA_W-1:0]  disk_addr,
  output logic [REG_W-1:0] word_cnt,
  output logic             addr_inh,
  output logic [1:0]       func_code,
  output logic             start_pulse,
  output logic             abort_pulse,
  output logic             irq
);
  localparam int ERRH = DAE_ERRL + NDERR - 1;

  logic             ie_q, done_q, start_q, abort_q;
  logic [MEX_W-1:0] mex_q;
  logic [1:0]       func_q;
  logic [NFLAG-1:0] fl_q;
  logic [REG_W-1:0] wc_q, cma_q, da_q, dae_q, dbr_q, mnt_q;

  logic [REG_W-1:0] rd_vec [NREG];
  logic [REG_W-1:0] cur, mval, cs_rd;
  logic [NREG-1:0]  we;
  logic             st_frz, st_ned, st_err;
  logic             soft_clr, go;

  // read side
  assign cs_rd = {st_err, st_frz, fl_q[3], fl_q[2], st_ned, fl_q[1], fl_q[0],
                  1'b0, done_q, ie_q, mex_q, 1'b0, func_q, 1'b0};
  always_comb begin
    rd_vec[RI_CS]  = cs_rd;
    rd_vec[RI_WC]  = wc_q;
    rd_vec[RI_MA]  = cma_q;
    rd_vec[RI_DA]  = da_q;
    rd_vec[RI_DAE] = dae_q & DAE_RMASK;
    rd_vec[RI_DBR] = dbr_q;
    rd_vec[RI_MNT] = mnt_q;
    rd_vec[RI_POS] = rot_pos;
  end
  assign cur       = rd_vec[bus_addr[SEL_W:1]];
  assign bus_rdata = cur;

  dkc_bus_merge u_merge (
    .sel(bus_sel), .wr(bus_wr), .byte_wr(bus_byte), .addr(bus_addr),
    .wdata(bus_wdata), .cur(cur), .we(we), .mval(mval)
  );

  dkc_status #(.CAP_W(CAP_W)) u_status (
    .flags(fl_q), .dae_err(dae_q[ERRH:DAE_ERRL]),
    .full_da({dae_q[EXT_W-1:0], da_q}), .cap(cap_words),
    .frz(st_frz), .ned(st_ned), .err(st_err)
  );

  assign soft_clr = we[RI_CS] && mval[CS_CLR];
  assign go       = mval[CS_GO] && done_q && (mval[CS_FNL+1:CS_FNL] != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0; done_q <= 1'b1; start_q <= 1'b0; abort_q <= 1'b0;
      mex_q <= '0; func_q <= '0; fl_q <= '0;
      wc_q <= '0; cma_q <= '0; da_q <= '0; dae_q <= '0; dbr_q <= '0; mnt_q <= '0;
    end else if (soft_clr) begin
      ie_q <= 1'b0; done_q <= 1'b1; start_q <= 1'b0; abort_q <= 1'b1;
      mex_q <= '0; func_q <= '0; fl_q <= '0;
      wc_q <= '0; cma_q <= '0; da_q <= '0; dae_q <= '0; dbr_q <= '0; mnt_q <= '0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      // engine side
      if (eng_done) done_q <= 1'b1;
      fl_q <= fl_q | eng_cs_err;
      dae_q[ERRH:DAE_ERRL] <= dae_q[ERRH:DAE_ERRL] | eng_dae_err;
      if (eng_upd) begin
        wc_q  <= eng_wc;
        cma_q <= {eng_ma[REG_W-1:1], 1'b0};
        mex_q <= eng_ma[MA_W-1:REG_W];
        da_q  <= eng_da[REG_W-1:0];
        dae_q[EXT_W-1:0] <= eng_da[DA_W-1:REG_W];
      end
      if (eng_dbr_we) dbr_q <= eng_dbr;
      // bus side wins over the engine
      if (we[RI_CS]) begin
        ie_q   <= mval[CS_IE];
        mex_q  <= mval[CS_MEXL+MEX_W-1:CS_MEXL];
        func_q <= mval[CS_FNL+1:CS_FNL];
        if (go) begin
          start_q <= 1'b1;
          done_q  <= 1'b0;
          fl_q    <= '0;
        end
      end
      if (we[RI_WC])  wc_q  <= mval;
      if (we[RI_MA])  cma_q <= {mval[REG_W-1:1], 1'b0};
      if (we[RI_DA])  da_q  <= mval;
      if (we[RI_DAE])
        dae_q[DAE_ERRL-1:0] <= (dae_q[DAE_ERRL-1:0] & ~DAE_WMASK[DAE_ERRL-1:0]) |
                               (mval[DAE_ERRL-1:0] & DAE_WMASK[DAE_ERRL-1:0]);
      if (we[RI_DBR]) dbr_q <= mval;
      if (we[RI_MNT]) mnt_q <= mval;
    end
  end

  dkc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .ie_q(ie_q),
    .ie_wr(we[RI_CS] && !soft_clr), .ie_new(mval[CS_IE]),
    .done_q(done_q), .done_set(eng_done), .ack(irq_ack), .irq(irq)
  );

  assign mem_addr    = {mex_q, cma_q};
  assign disk_addr   = {dae_q[EXT_W-1:0], da_q};
  assign word_cnt    = wc_q;
  assign addr_inh    = dae_q[DAE_INH];
  assign func_code   = func_q;
  assign start_pulse = start_q;
  assign abort_pulse = abort_q;
endmodule

// File: rtl/dkc_regfile_chk.sv
module dkc_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic        bus_byte,
  input logic [3:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [5:0]  eng_dae_err,
  input logic        start_pulse,
  input logic [1:0]  func_code,
  input logic        irq,
  input logic        done_q,
  input logic        ie_q,
  input logic        frz
);
  p_start_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(done_q) && !done_q && func_code != 2'd0));

  p_irq_needs_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ie_q);

  p_ie_off_drops_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_byte && bus_addr[3:1] == 3'd0 && !bus_wdata[6]) |=> !irq);

  p_dae_err_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_dae_err != 6'd0 && !(bus_sel && bus_wr)) |=> frz);

  p_cma_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:1] == 3'd2) |-> !bus_rdata[0]);

  p_err_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:1] == 3'd0) |-> (bus_rdata[15] == (|bus_rdata[14:9])));
endmodule

bind dkc_regfile dkc_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .eng_dae_err(eng_dae_err), .start_pulse(start_pulse),
  .func_code(func_code), .irq(irq), .done_q(done_q), .ie_q(ie_q), .frz(st_frz)
);

// File: tb/sim_dkc_regfile.sv
`timescale 1ns/1ps
module sim_dkc_regfile;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_byte = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic eng_upd = 0, eng_dbr_we = 0, eng_done = 0, irq_ack = 0;
  logic [15:0] eng_wc = 0, eng_dbr = 0, rot_pos = 16'h0123;
  logic [17:0] eng_ma = 0;
  logic [21:0] eng_da = 0;
  logic [3:0] eng_cs_err = 0;
  logic [5:0] eng_dae_err = 0;
  logic [22:0] cap_words = 23'd262144;
  logic [17:0] mem_addr;
  logic [21:0] disk_addr;
  logic [15:0] word_cnt;
  logic addr_inh, start_pulse, abort_pulse, irq;
  logic [1:0] func_code;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dkc_regfile u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d, input int mode);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_byte = (mode != 0);
    bus_addr = {idx[2:0], mode == 2}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_byte = 0;
  endtask

  task automatic rd(input int idx, input logic [15:0] exp, input string req);
    bus_addr = {idx[2:0], 1'b0};
    #0.5;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
  endtask

  task automatic pulse_err(input logic [3:0] e, input logic [5:0] de);
    @(negedge clk); eng_cs_err = e; eng_dae_err = de;
    @(negedge clk); eng_cs_err = 0; eng_dae_err = 0;
  endtask

  task automatic do_clear();
    wr(0, 16'h0100, 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    rd(0, 16'h0080, "R10 cs");
    for (int i = 1; i < 7; i++) rd(i, 16'h0000, "R10 reg");
    chk("R10 irq", irq, 0);
    chk("R10 start", start_pulse, 0);
    chk("R10 abort", abort_pulse, 0);
    // R1 word sweep on plain registers, position read only
    foreach (e[k]) begin end
    for (int p = 0; p < 16; p++) begin
      for (int r = 1; r < 7; r += 2) begin
        e = (16'h1111 * p[15:0]) ^ (16'h0F0F << r);
        wr(r, e, 0); rd(r, e, "R1 word");
      end
      e = 16'hA5A5 ^ p[15:0];
      wr(6, e, 0); rd(6, e, "R1 maint");
    end
    chk("R1 word_cnt", word_cnt, 16'hFFFF ^ (16'h0F0F << 1));
    wr(7, 16'hFFFF, 0); rd(7, 16'h0123, "R1 pos ignore");
    rot_pos = 16'h0456; rd(7, 16'h0456, "R1 pos live");
    // R2 byte lanes
    for (int r = 1; r < 7; r += 2) begin
      wr(r, 16'hA5C3, 0);
      wr(r, 16'h3C77, 2); rd(r, 16'h3CC3, "R2 odd");
      wr(r, 16'h995A, 1); rd(r, 16'h3C5A, "R2 even");
    end
    wr(6, 16'h1234, 0); wr(6, 16'hAB00, 2); rd(6, 16'hAB34, "R2 maint odd");
    // R9 masks
    for (int p = 0; p < 8; p++) begin
      e = 16'h2469 * p[15:0] + 16'h0001;
      wr(2, e, 0); rd(2, e & 16'hFFFE, "R9 ma");
    end
    wr(2, 16'h00FF, 1); rd(2, 16'hFFFE & ((e & 16'hFF00) | 16'h00FF), "R9 ma byte");
    wr(4, 16'hFFFF, 0); rd(4, 16'h01BF, "R9 dae");
    chk("R9 inh", addr_inh, 1);
    wr(4, 16'h0000, 0); rd(4, 16'h0000, "R9 dae zero");
    wr(3, 16'h0000, 0);
    // R3 status write
    wr(0, 16'hFEFE, 0); rd(0, 16'h00F6, "R3 cs keep");
    chk("R8 ie set with done", irq, 1);
    wr(0, 16'h0000, 0); rd(0, 16'h0080, "R3 cs zero");
    chk("R8 ie off", irq, 0);
    // R4 GO over all functions
    for (int f = 0; f < 4; f++) begin
      wr(0, 16'(f * 2 + 1), 0);
      chk("R4 start", start_pulse, f != 0);
      if (f != 0) begin
        chk("R4 func", func_code, f[1:0]);
        rd(0, 16'(f * 2), "R4 done cleared");
        wr(0, 16'(f * 2 + 1), 0);
        chk("R4 no start busy", start_pulse, 0);
        pulse_done();
        rd(0, 16'(16'h0080 + f * 2), "R11 done set");
      end else begin
        rd(0, 16'h0080, "R4 nop");
      end
    end
    pulse_err(4'hF, 6'h00);
    rd(0, 16'hB686, "R5 flags");
    wr(0, 16'h0003, 0);
    chk("R4 start flags", start_pulse, 1);
    rd(0, 16'h0002, "R4 flags cleared");
    pulse_done();
    // R5 sweep with clears (R3)
    for (int k = 0; k < 16; k++) begin
      do_clear();
      chk("R3 abort", abort_pulse, 1);
      pulse_err(k[3:0], 6'h00);
      e = 16'h0080 | (k[3] ? 16'h2000 : 0) | (k[2] ? 16'h1000 : 0) |
          (k[1] ? 16'h0400 : 0) | (k[0] ? 16'h0200 : 0) | (k != 0 ? 16'h8000 : 0);
      rd(0, e, "R5 err");
    end
    // R6 extension errors
    for (int j = 0; j < 6; j++) begin
      do_clear();
      pulse_err(4'h0, 6'(1 << j));
      rd(4, 16'(1 << (10 + j)), "R6 dae bit");
      rd(0, 16'hC080, "R6 frz");
      wr(4, 16'h0000, 0);
      rd(4, 16'(1 << (10 + j)), "R6 sticky");
    end
    do_clear();
    rd(0, 16'h0080, "R6 cleared");
    // R7 capacity compare
    cap_words = 23'd100;
    for (int d = 95; d < 105; d++) begin
      wr(3, 16'(d), 0);
      rd(0, (d >= 100) ? 16'h8880 : 16'h0080, "R7 ned");
    end
    cap_words = 23'd524288;
    wr(3, 16'h0000, 0);
    wr(4, 16'h0002, 0); rd(0, 16'h0080, "R7 ext below");
    wr(4, 16'h0008, 0); rd(0, 16'h8880, "R7 ext at cap");
    chk("R11 disk_addr", disk_addr, 22'h080000);
    do_clear();
    // R8 interrupt
    wr(0, 16'h0043, 0);
    chk("R8 ie rise", irq, 1);
    chk("R4 start ie", start_pulse, 1);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R8 ack", irq, 0);
    pulse_done();
    chk("R8 done rise", irq, 1);
    wr(0, 16'h0000, 0);
    chk("R8 withdraw", irq, 0);
    wr(0, 16'h0003, 0);
    pulse_done();
    chk("R8 no ie", irq, 0);
    // R11 engine loads
    @(negedge clk);
    eng_upd = 1; eng_wc = 16'h1234; eng_ma = 18'h2ABCD; eng_da = 22'h3F1234;
    eng_dbr_we = 1; eng_dbr = 16'h5A5A;
    @(negedge clk);
    eng_upd = 0; eng_dbr_we = 0;
    rd(1, 16'h1234, "R11 wc");
    rd(2, 16'hABCC, "R11 ma");
    rd(3, 16'h1234, "R11 da");
    rd(4, 16'h003F, "R11 ext");
    rd(5, 16'h5A5A, "R11 dbr");
    chk("R11 mem_addr", mem_addr, 18'h2ABCC);
    chk("R11 disk_addr", disk_addr, 22'h3F1234);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule